// File: doc/BRIEF.md
# Video and Cursor Burst Fetch Controller

This block keeps two word queues topped up for a video pipeline: one holds frame-buffer pixel words and the other holds hardware cursor sprite words. A single active-low request line goes to an external memory controller. That controller owns all address generation, and it answers every request with a burst of exactly four words on a 64-bit data bus. Each word is qualified by an acknowledge strobe. The block steers each acknowledged word into the queue whose refill started the burst.

The pixel side pops words with one read strobe per queue. A read from an empty queue sets a sticky underflow flag, and any register write clears it. The processor programs a small mode register through the same data bus. A two-bit lane field selects which half of the bus carries burst data, and a synchronous-mode bit must be clear for fetching to run. Cursor refills start only while horizontal sync is high, and they win over video refills when both queues have room. Only one burst is outstanding at a time.

Top module: `pixel_fetch_dma`

## Requirements
- R1: After reset the request output is high, both queues are empty, both underflow flags are low, and no request is raised until a register write enables fetching.
- R2: A register write (regWr high at a clock edge) loads the mode from busData bits [1:0] (lane field) and bit [2] (sync bit). Fetching is enabled when the lane field is nonzero and the sync bit is 0. Lane field 01 carries burst data on busData[31:0]. Lane field 10 or 11 carries it on busData[63:32]. Register data is always taken from the lower 32 bits.
- R3: When idle and enabled, a video burst starts if the video queue holds no more than VID_DEPTH-4 words and no cursor burst is due. dmaReqN goes low one cycle after the deciding edge.
- R4: A cursor burst starts only when hsync is high at the deciding edge and the cursor queue holds no more than CUR_DEPTH-4 words. When both conditions hold it takes priority over video.
- R5: dmaReqN stays low until the fourth acknowledged word, goes high the cycle after it, and stays high for at least one cycle between bursts. A burst that has started runs to its end even if the mode changes.
- R6: Each word acknowledged while a burst is outstanding enters the queue of that burst, from the lane selected by the mode in force. An acknowledge while dmaReqN is high has no effect.
- R7: vidData and curData show the oldest word of their queue whenever it is non-empty. A read strobe pops that word, so words leave in arrival order.
- R8: A read strobe on an empty queue leaves the queue unchanged and sets that queue's underflow flag, which then stays set.
- R9: A register write clears both underflow flags. A read of an empty queue in the same cycle still sets its flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWr | input | 1 | Processor register write strobe |
| hsync | input | 1 | Horizontal sync, high while active |
| dmaAck | input | 1 | Burst word acknowledge from the memory controller |
| busData | input | 2*WORD_W | Shared data bus |
| vidRd | input | 1 | Pop strobe for the video queue |
| curRd | input | 1 | Pop strobe for the cursor queue |
| dmaReqN | output | 1 | Active-low burst request |
| vidData | output | WORD_W | Oldest video word |
| curData | output | WORD_W | Oldest cursor word |
| vidUnderflow | output | 1 | Sticky video underflow flag |
| curUnderflow | output | 1 | Sticky cursor underflow flag |

## Verification
The bench builds the block with VID_DEPTH=8 and CUR_DEPTH=4. With these shallow queues the room threshold is crossed within a few bursts. In particular, a cursor burst becomes possible only when the cursor queue is completely empty. This makes both the refusal and the acceptance of a refill, and the cursor-over-video priority, frequent under random reads and sync pulses. Random mode writes move data between the lower and upper bus halves in the middle of a run and sometimes disable fetching. They also collide with reads of empty queues, which exercises the set-over-clear case of the underflow flags.

// File: rtl/fetch_pkg.sv
package fetch_pkg;
  localparam int BURST_LEN = 4;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_VID  = 2'd1,
    ST_CUR  = 2'd2
  } fetchState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic vidPush;
    logic curPush;
    logic regLoad;
  } fetchStrobe_t;

  // status from datapath to control
  typedef struct packed {
    logic dmaEnable;
    logic vidRoom;
    logic curRoom;
  } fetchStatus_t;
endpackage

// File: rtl/wordFifo.sv
module wordFifo #(
  parameter int WIDTH = 32,
  parameter int DEPTH = 16,
  parameter int ROOM  = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             push,
  input  logic [WIDTH-1:0] pushData,
  input  logic             pop,
  output logic [WIDTH-1:0] headData,
  output logic             empty,
  output logic             hasRoom
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wrPtr, rdPtr;
  logic [CW-1:0]    count;
  logic             doPush, doPop;

  assign doPop   = pop && (count != '0);
  assign doPush  = push && (count != CW'(DEPTH));
  assign empty   = (count == '0);
  assign hasRoom = (count <= CW'(DEPTH - ROOM));
  assign headData = mem[rdPtr];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (doPush) wrPtr <= wrPtr + 1'b1;
      if (doPop)  rdPtr <= rdPtr + 1'b1;
      count <= count + CW'(doPush) - CW'(doPop);
    end
  end

  always_ff @(posedge clk) begin
    if (doPush) mem[wrPtr] <= pushData;
  end
endmodule

// File: rtl/fetchPath.sv
module fetchPath
  import fetch_pkg::*;
#(
  parameter int WORD_W    = 32,
  parameter int VID_DEPTH = 16,
  parameter int CUR_DEPTH = 8
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  fetchStrobe_t          strobe,
  input  logic [2*WORD_W-1:0]   busData,
  input  logic                  vidRd,
  input  logic                  curRd,
  output logic [WORD_W-1:0]     vidData,
  output logic [WORD_W-1:0]     curData,
  output logic                  vidUnderflow,
  output logic                  curUnderflow,
  output fetchStatus_t          status
);
  localparam int BUS_W = 2 * WORD_W;

  logic [1:0]        laneField;
  logic              syncBit;
  logic [WORD_W-1:0] laneWord;
  logic [1:0]        pushV, rdV, emptyV, roomV, uflowV;
  logic [WORD_W-1:0] headV [2];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      laneField <= 2'b00;
      syncBit   <= 1'b0;
    end else if (strobe.regLoad) begin
      laneField <= busData[1:0];
      syncBit   <= busData[2];
    end
  end

  assign laneWord = laneField[1] ? busData[BUS_W-1:WORD_W] : busData[WORD_W-1:0];

  assign pushV = {strobe.curPush, strobe.vidPush};
  assign rdV   = {curRd, vidRd};

  for (genvar ch = 0; ch < 2; ch++) begin : g_chan
    localparam int D = (ch == 0) ? VID_DEPTH : CUR_DEPTH;
    logic uf;

    wordFifo #(.WIDTH(WORD_W), .DEPTH(D), .ROOM(BURST_LEN)) u_fifo (
      .clk      (clk),
      .rstN     (rstN),
      .push     (pushV[ch]),
      .pushData (laneWord),
      .pop      (rdV[ch]),
      .headData (headV[ch]),
      .empty    (emptyV[ch]),
      .hasRoom  (roomV[ch])
    );

    // set beats clear when both happen in one cycle
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) uf <= 1'b0;
      else       uf <= (uf && !strobe.regLoad) || (rdV[ch] && emptyV[ch]);
    end
    assign uflowV[ch] = uf;
  end

  assign vidData      = headV[0];
  assign curData      = headV[1];
  assign vidUnderflow = uflowV[0];
  assign curUnderflow = uflowV[1];

  assign status.dmaEnable = (laneField != 2'b00) && !syncBit;
  assign status.vidRoom   = roomV[0];
  assign status.curRoom   = roomV[1];
endmodule

// File: rtl/fetchCtrl.sv
module fetchCtrl
  import fetch_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         hsync,
  input  logic         dmaAck,
  input  logic         regWr,
  input  fetchStatus_t status,
  output fetchStrobe_t strobe,
  output logic         dmaReqN,
  output logic         burstIsCur
);
  fetchState_t state, stateNext;
  logic [1:0]  beat;

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE: begin
        if (status.dmaEnable) begin
          if (hsync && status.curRoom) stateNext = ST_CUR;
          else if (status.vidRoom)     stateNext = ST_VID;
        end
      end
      ST_VID, ST_CUR: begin
        if (dmaAck && beat == 2'd3) stateNext = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      beat  <= 2'd0;
    end else begin
      state <= stateNext;
      if (state == ST_IDLE)  beat <= 2'd0;
      else if (dmaAck)       beat <= beat + 2'd1;
    end
  end

  assign strobe.vidPush = (state == ST_VID) && dmaAck;
  assign strobe.curPush = (state == ST_CUR) && dmaAck;
  assign strobe.regLoad = regWr;
  assign dmaReqN        = (state == ST_IDLE);
  assign burstIsCur     = (state == ST_CUR);
endmodule

// File: rtl/pixel_fetch_dma.sv
module pixel_fetch_dma
  import fetch_pkg::*;
#(
  parameter int WORD_W    = 32,
  parameter int VID_DEPTH = 16,
  parameter int CUR_DEPTH = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                regWr,
  input  logic                hsync,
  input  logic                dmaAck,
  input  logic [2*WORD_W-1:0] busData,
  input  logic                vidRd,
  input  logic                curRd,
  output logic                dmaReqN,
  output logic [WORD_W-1:0]   vidData,
  output logic [WORD_W-1:0]   curData,
  output logic                vidUnderflow,
  output logic                curUnderflow
);
  fetchStrobe_t strobe;
  fetchStatus_t status;
  logic         burstIsCur;

  fetchCtrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .hsync      (hsync),
    .dmaAck     (dmaAck),
    .regWr      (regWr),
    .status     (status),
    .strobe     (strobe),
    .dmaReqN    (dmaReqN),
    .burstIsCur (burstIsCur)
  );

  fetchPath #(.WORD_W(WORD_W), .VID_DEPTH(VID_DEPTH), .CUR_DEPTH(CUR_DEPTH)) u_path (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .busData      (busData),
    .vidRd        (vidRd),
    .curRd        (curRd),
    .vidData      (vidData),
    .curData      (curData),
    .vidUnderflow (vidUnderflow),
    .curUnderflow (curUnderflow),
    .status       (status)
  );
endmodule

// File: rtl/pixel_fetch_dma_chk.sv
module pixel_fetch_dma_chk (
  input logic clk,
  input logic rstN,
  input logic regWr,
  input logic hsync,
  input logic dmaAck,
  input logic vidRd,
  input logic curRd,
  input logic dmaReqN,
  input logic vidUnderflow,
  input logic curUnderflow,
  input logic burstIsCur
);
  logic       cfgSeen;
  logic [1:0] ackCount;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgSeen  <= 1'b0;
      ackCount <= 2'd0;
    end else begin
      if (regWr) cfgSeen <= 1'b1;
      if (dmaReqN)     ackCount <= 2'd0;
      else if (dmaAck) ackCount <= ackCount + 2'd1;
    end
  end

  assert_idle_before_config_R1: assert property (@(posedge clk) disable iff (!rstN)
    !cfgSeen |-> dmaReqN);

  assert_cursor_needs_hsync_R4: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(dmaReqN) && burstIsCur) |-> $past(hsync));

  assert_hold_request_R5: assert property (@(posedge clk) disable iff (!rstN)
    (!dmaReqN && !(dmaAck && ackCount == 2'd3)) |=> !dmaReqN);

  assert_release_request_R5: assert property (@(posedge clk) disable iff (!rstN)
    (!dmaReqN && dmaAck && ackCount == 2'd3) |=> dmaReqN);

  assert_vid_sticky_R8: assert property (@(posedge clk) disable iff (!rstN)
    (vidUnderflow && !regWr) |=> vidUnderflow);

  assert_cur_sticky_R8: assert property (@(posedge clk) disable iff (!rstN)
    (curUnderflow && !regWr) |=> curUnderflow);

  assert_flag_clear_R9: assert property (@(posedge clk) disable iff (!rstN)
    (regWr && !vidRd && !curRd) |=> (!vidUnderflow && !curUnderflow));
endmodule

bind pixel_fetch_dma pixel_fetch_dma_chk u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .regWr        (regWr),
  .hsync        (hsync),
  .dmaAck       (dmaAck),
  .vidRd        (vidRd),
  .curRd        (curRd),
  .dmaReqN      (dmaReqN),
  .vidUnderflow (vidUnderflow),
  .curUnderflow (curUnderflow),
  .burstIsCur   (burstIsCur)
);

// File: tb/tb_pixel_fetch_dma.sv
`timescale 1ns/1ps
module tb_pixel_fetch_dma;
  localparam int WORD_W = 32;
  localparam int VID_D  = 8;
  localparam int CUR_D  = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWr = 1'b0, hsync = 1'b0, dmaAck = 1'b0, vidRd = 1'b0, curRd = 1'b0;
  logic [63:0] busData = '0;
  logic dmaReqN, vidUnderflow, curUnderflow;
  logic [WORD_W-1:0] vidData, curData;

  always #2.5 clk = ~clk;

  pixel_fetch_dma #(.WORD_W(WORD_W), .VID_DEPTH(VID_D), .CUR_DEPTH(CUR_D)) dut (
    .clk(clk), .rstN(rstN), .regWr(regWr), .hsync(hsync), .dmaAck(dmaAck),
    .busData(busData), .vidRd(vidRd), .curRd(curRd), .dmaReqN(dmaReqN),
    .vidData(vidData), .curData(curData),
    .vidUnderflow(vidUnderflow), .curUnderflow(curUnderflow));

  int checks = 0, fails = 0;
  bit done = 0;

  // reference state: 0 idle, 1 video burst, 2 cursor burst
  int mSt = 0, mBeat = 0;
  bit mEn = 0, mUpper = 0, mVuf = 0, mCuf = 0;
  logic [31:0] vq[$], cq[$];

  task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, got, exp, $time);
    end
  endtask

  function automatic int nextState(input bit h, input bit ack);
    if (mSt == 0) begin
      if (!mEn) return 0;
      if (h && cq.size() <= CUR_D - 4) return 2;
      if (vq.size() <= VID_D - 4) return 1;
      return 0;
    end
    if (ack && mBeat == 3) return 0;
    return mSt;
  endfunction

  // called just after a negedge: check outputs, drive inputs, advance model
  task automatic runCycle(input bit iWr, input bit iH, input bit iAck,
                          input bit iVr, input bit iCr, input logic [63:0] iBus);
    string tag;
    bit vEmpty, cEmpty;
    logic [31:0] word;
    int ns;
    tag = (mSt == 2) ? "R4" : (mSt == 1) ? "R5" : "R3";
    check(tag, dmaReqN, (mSt == 0));
    if (vq.size() > 0) check("R7", vidData, vq[0]);
    if (cq.size() > 0) check("R6", curData, cq[0]);
    check("R8", vidUnderflow, mVuf);
    check("R9", curUnderflow, mCuf);

    regWr = iWr; hsync = iH; dmaAck = iAck; vidRd = iVr; curRd = iCr; busData = iBus;

    ns = nextState(iH, iAck);
    vEmpty = (vq.size() == 0);
    cEmpty = (cq.size() == 0);
    word = mUpper ? iBus[63:32] : iBus[31:0];
    if (iVr && !vEmpty) void'(vq.pop_front());
    if (iCr && !cEmpty) void'(cq.pop_front());
    if (mSt == 1 && iAck) vq.push_back(word);
    if (mSt == 2 && iAck) cq.push_back(word);
    mVuf = (mVuf && !iWr) || (iVr && vEmpty);
    mCuf = (mCuf && !iWr) || (iCr && cEmpty);
    if (iWr) begin
      mEn = (iBus[1:0] != 2'b00) && !iBus[2];
      mUpper = iBus[1];
    end
    if (mSt != 0 && iAck) mBeat = (mBeat + 1) % 4;
    if (ns == 0) mBeat = 0;
    mSt = ns;
    @(negedge clk);
  endtask

  function automatic logic [63:0] rnd64();
    return {$urandom(), $urandom()};
  endfunction

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // reset state, R1
    check("R1", dmaReqN, 1'b1);
    check("R1", vidUnderflow, 1'b0);
    check("R1", curUnderflow, 1'b0);
    rstN = 1'b1;
    @(negedge clk);
    // unconfigured: no request even with hsync and acks (R1, R6)
    for (int i = 0; i < 10; i++) runCycle(0, i[0], 1, 0, 0, rnd64());
    check("R1", dmaReqN, 1'b1);
    // empty read sets flag, R8
    runCycle(0, 0, 0, 1, 1, '0);
    runCycle(0, 0, 0, 0, 0, '0);
    check("R8", vidUnderflow, 1'b1);
    // write with field 00: still disabled, flags cleared while a read of empty sets cursor (R2, R9)
    runCycle(1, 0, 0, 0, 1, 64'h0);
    runCycle(0, 0, 0, 0, 0, '0);
    check("R9", vidUnderflow, 1'b0);
    check("R9", curUnderflow, 1'b1);
    check("R2", dmaReqN, 1'b1);
    // sync bit set with valid lane: still disabled, R2
    runCycle(1, 0, 0, 0, 0, 64'h5);
    for (int i = 0; i < 4; i++) runCycle(0, 0, 0, 0, 0, '0);
    check("R2", dmaReqN, 1'b1);
    // upper lane mode and a video burst, R2 R3 R6
    runCycle(1, 0, 0, 0, 0, 64'hDEAD_BEEF_0000_0002);
    for (int i = 0; i < 12; i++) runCycle(0, 0, !dmaReqN, 0, 0, rnd64());
    // lower lane, sync pulse: cursor priority R4
    runCycle(1, 0, 0, 0, 0, 64'h1);
    for (int i = 0; i < 30; i++) runCycle(0, 1, !dmaReqN, (i % 3) == 0, 0, rnd64());
    // random mix
    for (int i = 0; i < 6000; i++) begin
      bit h, w;
      logic [63:0] b;
      h = hsync;
      if ($urandom_range(19) == 0) h = !h;
      w = ($urandom_range(99) == 0);
      b = rnd64();
      if (w) begin
        case ($urandom_range(9))
          0: b[2:0] = 3'b000;
          1: b[2:0] = 3'b101;
          2, 3: b[2:0] = 3'b010;
          4: b[2:0] = 3'b011;
          default: b[2:0] = 3'b001;
        endcase
      end
      runCycle(w, h, dmaReqN ? ($urandom_range(9) == 0) : ($urandom_range(9) < 7),
               $urandom_range(9) < 3, $urandom_range(9) < 2, b);
    end
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(5 * 150000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule